// File: doc/BRIEF.md
# Privilege-Masked Interrupt Pending and Enable Unit

This unit holds the interrupt state of a small core. It has a pending register and an enable register, each one word wide with one bit per interrupt cause. Interrupt sources raise a cause by posting its index, and they withdraw it with a per-index clear. A single clear-all request empties the whole pending set. Software reads both registers as whole words. A word write replaces the full contents of either register.

Three global enable bits come from the core's status register, one each for the machine, supervisor and user levels. Each bit unmasks the software, timer and external causes of its own level. The unit raises a request flag when some cause is pending, enabled and unmasked. It also gives a 4-bit code for the lowest-numbered such cause. The request and the code are combinational from the stored registers and the status bits, so a change to a status bit takes effect in the same cycle. A separate probe port reports pending AND enabled for one chosen index, and it ignores the global mask.

Top module: `intr_pend_unit`

## Requirements
- R1: After reset, both the pending and the enable register read zero, irqReq is low and causeCode is zero.
- R2: Only bits 0, 1, 3 (user, supervisor and machine software), 4, 5, 7 (timers) and 8, 9, 11 (external) are implemented. Every other bit always reads zero and ignores writes and posts.
- R3: glbMachEn unmasks bits 3, 7 and 11. glbSupEn unmasks bits 1, 5 and 9. glbUserEn unmasks bits 0, 4 and 8.
- R4: irqReq is high exactly when some bit is set in pending AND enable AND the global mask. It follows the status inputs in the same cycle, with no register delay.
- R5: causeCode is the lowest index that is pending, enabled and unmasked, given as a 4-bit binary number. It is zero whenever irqReq is low.
- R6: When postValid is high, bit postIdx of the pending register is set at the next clock edge. When clearValid is high, bit clearIdx is cleared. If both name the same index in one cycle, the clear wins.
- R7: When clearAll is high, the pending register is zero after the next edge. A post or clear in the same cycle has no effect.
- R8: When wrPend or wrEnab is high, the pending or enable register becomes wrData (implemented bits only) after the next edge. A pending write takes precedence over post, clear and clear-all in the same cycle.
- R9: probeHit equals pending[probeIdx] AND enable[probeIdx], whatever the state of the global enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| postValid | input | 1 | Set one pending bit |
| postIdx | input | 5 | Index of the bit to set |
| clearValid | input | 1 | Clear one pending bit |
| clearIdx | input | 5 | Index of the bit to clear |
| clearAll | input | 1 | Clear the whole pending register |
| wrPend | input | 1 | Word write to the pending register |
| wrEnab | input | 1 | Word write to the enable register |
| wrData | input | 32 | Write data for either register |
| glbMachEn | input | 1 | Machine-level global enable |
| glbSupEn | input | 1 | Supervisor-level global enable |
| glbUserEn | input | 1 | User-level global enable |
| probeIdx | input | 5 | Index for the unmasked per-cause check |
| pendWord | output | 32 | Pending register read value |
| enabWord | output | 32 | Enable register read value |
| probeHit | output | 1 | Pending AND enabled at probeIdx |
| irqReq | output | 1 | An interrupt qualifies (also the valid bit for causeCode) |
| causeCode | output | 4 | Lowest qualifying cause index |

## Verification
The assertions check these rules on every cycle:
- a reported cause really is pending, enabled and unmasked, and no lower index also qualifies;
- the code stays zero when nothing qualifies;
- unimplemented bits never read as set;
- each request type has its one-cycle effect on the registers.

Some behaviour only the bench scenarios can show. These are the exact way the three status bits map to the nine causes, and the precedence cases: a clear against a post of the same index, clear-all against a post, and a word write against all of them. The scenarios also show that the probe port ignores the status bits while irqReq does not.

// File: rtl/intr_pend_pkg.sv
package intr_pend_pkg;

  // Cause positions used by the unit (12 low bits carry all causes)
  localparam int CAUSE_SPAN = 12;
  localparam logic [CAUSE_SPAN-1:0] LEVEL_USER_BITS = 12'h111;
  localparam logic [CAUSE_SPAN-1:0] LEVEL_SUP_BITS  = 12'h222;
  localparam logic [CAUSE_SPAN-1:0] LEVEL_MACH_BITS = 12'h888;
  localparam logic [CAUSE_SPAN-1:0] IMPL_BITS =
    LEVEL_USER_BITS | LEVEL_SUP_BITS | LEVEL_MACH_BITS;

  // Strobes from control to datapath
  typedef struct packed {
    logic setOk;   // apply single-bit post
    logic clrOk;   // apply single-bit clear
    logic wipe;    // zero the pending register
    logic ldPend;  // replace pending with write data
    logic ldEnab;  // replace enable with write data
  } irq_strobe_t;

endpackage

// File: rtl/intr_pend_ctrl.sv
module intr_pend_ctrl
  import intr_pend_pkg::*;
(
  input  logic        postValid,
  input  logic        clearValid,
  input  logic        clearAll,
  input  logic        wrPend,
  input  logic        wrEnab,
  output irq_strobe_t strobe
);

  // Precedence: word write > clear-all > per-bit post/clear
  always_comb begin
    strobe.ldPend = wrPend;
    strobe.ldEnab = wrEnab;
    strobe.wipe   = clearAll && !wrPend;
    strobe.setOk  = postValid && !clearAll && !wrPend;
    strobe.clrOk  = clearValid && !clearAll && !wrPend;
  end

endmodule

// File: rtl/intr_pend_prio.sv
module intr_pend_prio #(
  parameter int WIDTH  = 32,
  parameter int CODE_W = 4
) (
  input  logic [WIDTH-1:0]  qual,
  output logic              hit,
  output logic [CODE_W-1:0] code
);

  localparam int SCAN = (WIDTH < (1 << CODE_W)) ? WIDTH : (1 << CODE_W);

  assign hit = |qual;

  // Scan downwards so the lowest set index is the last one written
  always_comb begin
    code = '0;
    for (int i = SCAN - 1; i >= 0; i--) begin
      if (qual[i]) code = i[CODE_W-1:0];
    end
  end

endmodule

// File: rtl/intr_pend_dp.sv
module intr_pend_dp
  import intr_pend_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_strobe_t      strobe,
  input  logic [IDX_W-1:0] postIdx,
  input  logic [IDX_W-1:0] clearIdx,
  input  logic [XLEN-1:0]  wrData,
  input  logic [2:0]       levelEn,   // {mach, sup, user}
  input  logic [IDX_W-1:0] probeIdx,
  output logic [XLEN-1:0]  pendQ,
  output logic [XLEN-1:0]  enabQ,
  output logic [XLEN-1:0]  qualVec,
  output logic             probeHit
);

  localparam logic [XLEN-1:0] IMPL = XLEN'(IMPL_BITS);
  localparam logic [XLEN-1:0] ONE  = XLEN'(1);
  localparam logic [CAUSE_SPAN-1:0] LEVEL_TAB [3] =
    '{LEVEL_USER_BITS, LEVEL_SUP_BITS, LEVEL_MACH_BITS};

  logic [XLEN-1:0] pendNext, enabNext, setVec, clrVec, globMask;
  logic [XLEN-1:0] levelPart [3];

  // Per-level contribution to the global mask
  genvar lv;
  generate
    for (lv = 0; lv < 3; lv++) begin : g_level
      assign levelPart[lv] = levelEn[lv] ? XLEN'(LEVEL_TAB[lv]) : '0;
    end
  endgenerate
  assign globMask = levelPart[0] | levelPart[1] | levelPart[2];

  assign setVec = strobe.setOk ? (ONE << postIdx)  : '0;
  assign clrVec = strobe.clrOk ? (ONE << clearIdx) : '0;

  always_comb begin
    if (strobe.ldPend)    pendNext = wrData & IMPL;
    else if (strobe.wipe) pendNext = '0;
    else                  pendNext = ((pendQ | setVec) & ~clrVec) & IMPL;
    enabNext = strobe.ldEnab ? (wrData & IMPL) : enabQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ <= '0;
      enabQ <= '0;
    end else begin
      pendQ <= pendNext;
      enabQ <= enabNext;
    end
  end

  assign qualVec  = pendQ & enabQ & globMask;
  assign probeHit = pendQ[probeIdx] & enabQ[probeIdx];

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendQ | enabQ) & ~IMPL) == '0);  // R2

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wipe) |=> (pendQ == '0));  // R7

  AST_ENAB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.ldEnab) |=> $stable(enabQ));  // R8

endmodule

// File: rtl/intr_pend_unit.sv
module intr_pend_unit
  import intr_pend_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4,
  localparam int IDX_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              postValid,
  input  logic [IDX_W-1:0]  postIdx,
  input  logic              clearValid,
  input  logic [IDX_W-1:0]  clearIdx,
  input  logic              clearAll,
  input  logic              wrPend,
  input  logic              wrEnab,
  input  logic [XLEN-1:0]   wrData,
  input  logic              glbMachEn,
  input  logic              glbSupEn,
  input  logic              glbUserEn,
  input  logic [IDX_W-1:0]  probeIdx,
  output logic [XLEN-1:0]   pendWord,
  output logic [XLEN-1:0]   enabWord,
  output logic              probeHit,
  output logic              irqReq,
  output logic [CODE_W-1:0] causeCode
);

  irq_strobe_t     strobe;
  logic [XLEN-1:0] qualVec;

  intr_pend_ctrl u_ctrl (
    .postValid (postValid),
    .clearValid(clearValid),
    .clearAll  (clearAll),
    .wrPend    (wrPend),
    .wrEnab    (wrEnab),
    .strobe    (strobe)
  );

  intr_pend_dp #(.XLEN(XLEN), .IDX_W(IDX_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .postIdx (postIdx),
    .clearIdx(clearIdx),
    .wrData  (wrData),
    .levelEn ({glbMachEn, glbSupEn, glbUserEn}),
    .probeIdx(probeIdx),
    .pendQ   (pendWord),
    .enabQ   (enabWord),
    .qualVec (qualVec),
    .probeHit(probeHit)
  );

  intr_pend_prio #(.WIDTH(XLEN), .CODE_W(CODE_W)) u_prio (
    .qual(qualVec),
    .hit (irqReq),
    .code(causeCode)
  );

  // Checks across datapath and encoder outputs
  localparam logic [XLEN-1:0] IMPL_W = XLEN'(IMPL_BITS);
  logic [XLEN-1:0] belowCode;
  logic [XLEN-1:0] chkMask;
  always_comb begin
    belowCode = (XLEN'(1) << causeCode) - XLEN'(1);
    chkMask = (glbMachEn ? XLEN'(LEVEL_MACH_BITS) : '0)
            | (glbSupEn  ? XLEN'(LEVEL_SUP_BITS)  : '0)
            | (glbUserEn ? XLEN'(LEVEL_USER_BITS) : '0);
  end

  AST_CAUSE_QUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (pendWord[causeCode] && enabWord[causeCode] && chkMask[causeCode]));  // R4

  AST_CAUSE_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> ((pendWord & enabWord & chkMask & belowCode) == '0));  // R5

  AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irqReq |-> (causeCode == '0));  // R5

  AST_POST_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (postValid && !clearAll && !wrPend && IMPL_W[postIdx] &&
     !(clearValid && clearIdx == postIdx)) |=> pendWord[$past(postIdx)]);  // R6

  AST_PEND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wrPend |=> (pendWord == ($past(wrData) & IMPL_W)));  // R8

endmodule

// File: tb/intr_pend_unit_tb_top.sv
`timescale 1ns/1ps
module intr_pend_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        postValid = 0, clearValid = 0, clearAll = 0;
  logic [4:0]  postIdx = 0, clearIdx = 0, probeIdx = 0;
  logic        wrPend = 0, wrEnab = 0;
  logic [31:0] wrData = 0;
  logic        glbMachEn = 0, glbSupEn = 0, glbUserEn = 0;
  logic [31:0] pendWord, enabWord;
  logic        probeHit, irqReq;
  logic [3:0]  causeCode;

  int testsRun = 0;
  int testsFailed = 0;
  string scen = "R1";

  bit [31:0] mPend = 0, mEnab = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  intr_pend_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .postValid(postValid), .postIdx(postIdx),
    .clearValid(clearValid), .clearIdx(clearIdx),
    .clearAll(clearAll), .wrPend(wrPend), .wrEnab(wrEnab), .wrData(wrData),
    .glbMachEn(glbMachEn), .glbSupEn(glbSupEn), .glbUserEn(glbUserEn),
    .probeIdx(probeIdx),
    .pendWord(pendWord), .enabWord(enabWord), .probeHit(probeHit),
    .irqReq(irqReq), .causeCode(causeCode)
  );

  function automatic bit [31:0] implBits();
    bit [31:0] m = 0;
    int pos [9] = '{0, 1, 3, 4, 5, 7, 8, 9, 11};
    foreach (pos[k]) m[pos[k]] = 1'b1;
    return m;
  endfunction

  function automatic bit [31:0] levelMask();
    bit [31:0] m = 0;
    if (glbUserEn) begin m[0] = 1; m[4] = 1; m[8] = 1; end
    if (glbSupEn)  begin m[1] = 1; m[5] = 1; m[9] = 1; end
    if (glbMachEn) begin m[3] = 1; m[7] = 1; m[11] = 1; end
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s (scenario %s): actual %h expected %h", req, scen, act, exp);
    end
  endtask

  task automatic compareAll();
    bit [31:0] q;
    int first;
    q = mPend & mEnab & levelMask();
    first = 0;
    for (int i = 31; i >= 0; i--) if (q[i]) first = i;
    check("R6 pend", pendWord, mPend);
    check("R8 enab", enabWord, mEnab);
    check("R4 irq", {31'b0, irqReq}, {31'b0, q != 0});
    check("R5 code", {28'b0, causeCode}, (q != 0) ? 32'(first) : 32'd0);
    check("R9 probe", {31'b0, probeHit}, {31'b0, mPend[probeIdx] & mEnab[probeIdx]});
  endtask

  // Reference model update at each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mPend = 0;
      mEnab = 0;
    end else begin
      if (wrPend) mPend = wrData;
      else if (clearAll) mPend = 0;
      else begin
        if (postValid)  mPend[postIdx] = 1'b1;
        if (clearValid) mPend[clearIdx] = 1'b0;
      end
      if (wrEnab) mEnab = wrData;
      mPend &= implBits();
      mEnab &= implBits();
    end
    #1 if (rst_n) compareAll();
  end

  task automatic idle();
    postValid = 0; clearValid = 0; clearAll = 0; wrPend = 0; wrEnab = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setLevels(bit m, bit s, bit u);
    glbMachEn = m; glbSupEn = s; glbUserEn = u;
  endtask

  bit finished = 0;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    #0.5;
    scen = "R1";
    check("R1 pend", pendWord, 0);
    check("R1 enab", enabWord, 0);
    check("R1 irq", {31'b0, irqReq}, 0);
    check("R1 code", {28'b0, causeCode}, 0);

    // R2: write all ones, only implemented bits stick
    tick(); scen = "R2";
    wrData = 32'hFFFF_FFFF; wrEnab = 1; wrPend = 1;
    tick(); idle();
    check("R2 enab", enabWord, 32'h0000_0BBB);
    wrPend = 1; wrData = 0;
    tick(); idle();
    postValid = 1; postIdx = 6;  // unimplemented
    tick(); idle();
    check("R2 post ignored", pendWord, 0);

    // R3: levels unmask their own causes
    scen = "R3";
    wrPend = 1; wrData = 32'h0000_0BBB;
    tick(); idle();
    setLevels(0, 0, 0); #0.5 check("R3 none", {31'b0, irqReq}, 0);
    setLevels(1, 0, 0); #0.5 check("R3 mach", {28'b0, causeCode}, 3);
    setLevels(0, 1, 0); #0.5 check("R3 sup",  {28'b0, causeCode}, 1);
    setLevels(0, 0, 1); #0.5 check("R3 user", {28'b0, causeCode}, 0);
    probeIdx = 7; setLevels(0, 0, 0);
    #0.5 check("R9 probe unmasked", {31'b0, probeHit}, 1);
    tick();

    // R5: lowest wins among timers/externals
    scen = "R5";
    wrPend = 1; wrData = 32'h0000_0A20;  // bits 5, 9, 11
    tick(); idle();
    setLevels(1, 1, 0); #0.5 check("R5 low", {28'b0, causeCode}, 5);
    tick();

    // R6: post and clear same index -> clear wins
    scen = "R6";
    postValid = 1; postIdx = 4; clearValid = 1; clearIdx = 4;
    tick(); idle();
    check("R6 clear wins", {31'b0, pendWord[4]}, 0);
    postValid = 1; postIdx = 8;
    tick(); idle();
    check("R6 post", {31'b0, pendWord[8]}, 1);

    // R7: clear-all beats post
    scen = "R7";
    clearAll = 1; postValid = 1; postIdx = 3;
    tick(); idle();
    check("R7 wipe", pendWord, 0);

    // R8: pending write beats clear-all and post
    scen = "R8";
    wrPend = 1; wrData = 32'h0000_0002; clearAll = 1; postValid = 1; postIdx = 0;
    tick(); idle();
    check("R8 write wins", pendWord, 32'h0000_0002);

    // Mixed random traffic compared every edge
    scen = "R4";
    for (int n = 0; n < 2000; n++) begin
      postValid  = ($urandom % 3) == 0;
      postIdx    = 5'($urandom % 13);
      clearValid = ($urandom % 4) == 0;
      clearIdx   = 5'($urandom % 13);
      clearAll   = ($urandom % 29) == 0;
      wrPend     = ($urandom % 23) == 0;
      wrEnab     = ($urandom % 11) == 0;
      wrData     = $urandom;
      probeIdx   = 5'($urandom);
      setLevels(1'($urandom), 1'($urandom), 1'($urandom));
      tick();
    end
    idle();
    tick();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule